// File: doc/BRIEF.md
# Scan Queue Trigger Controller

This block sequences one conversion queue of a multi-channel sampling engine. A 5-bit mode input selects the trigger source and the scan type. The source is a software pulse, a rising or falling edge on an external trigger line, or a power-of-two interval timer that runs from a prescaled clock. The scan type is single-scan or continuous-scan. When a scan is triggered, the block walks a command-word pointer from the queue start pointer up to the entry just below the boundary pointer. It raises a conversion request for each entry and advances the pointer on each conversion-done pulse.

The block keeps three sticky flags: scan complete, scan paused and trigger overrun. It reports them, together with a read-only queue-state field and the current pointer, in a 16-bit status word. A flag is cleared by writing 0 to its bit. Writing 1 to it leaves it unchanged. A stop input clears the whole status word and returns the queue to its idle state. The converter itself is modelled by the single-cycle `conv_done_i` input.

Top module: `scan_queue_ctrl`

## Requirements
- R1: Mode codes 01011-01110 and 10001-11110 are implemented. Every other code (reserved 01111, 10000, 11111 and all codes below 01011) holds the queue disabled: queue state 000, `conv_req_o` low, pointer at the start pointer, and triggers set no flag.
- R2: In mode 10001, a one-cycle `sw_trig_i` pulse while the queue is armed (state 001) starts a scan at the next clock edge. The state becomes 010, `conv_req_o` rises and `cwp_o` equals `start_ptr_i`.
- R3: While scanning, each `conv_done_i` pulse advances the pointer by one. The done pulse on the entry at `bound_ptr_i`-1 ends the pass: the complete flag (status bit 0) sets, the pointer returns to the start, and in continuous modes the state goes back to armed.
- R4: Mode 10010 starts a scan on a rising edge of `ext_trig_i`. Mode 10011 starts a scan on a falling edge. The opposite edge does nothing.
- R5: Modes 10100-11110 are continuous and timer-driven, with period 2^(code-13) prescaled ticks (2^7 up to 2^17). The first scan starts 2^n ticks after the mode is applied, and later scans start every 2^n ticks.
- R6: Modes 01011-01110 are single-scan and timer-driven, with period 2^(code+3) ticks (2^14 up to 2^17). After one pass the queue enters state 100 and ignores all later triggers.
- R7: A done pulse with `pause_i` high on an entry other than the last sets the pause flag (status bit 1), advances the pointer and moves the queue to state 011 with `conv_req_o` low. The next trigger resumes the scan at that pointer. On the last entry, `pause_i` is ignored.
- R8: A trigger that arrives while the queue is in state 010 sets the overrun flag (status bit 2) and leaves the pointer and the scan unchanged.
- R9: A status write ANDs the flag bits with the written data, so a 0 clears a flag and a 1 has no effect. The queue state (bits 6:4) and the pointer (bits 8 and up) ignore writes. A flag set in the same cycle as a clearing write stays set.
- R10: `stop_i` clears every flag, forces state 000 and drops `conv_req_o` at the next edge. One cycle after `stop_i` falls, a valid mode re-arms the queue.
- R11: Any change of `mode_i` abandons the current scan, loads the start pointer, restarts the timer and puts the queue in armed state for a valid code or disabled state otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Stop request, clears status and idles the queue |
| mode_i | input | 5 | Trigger source and scan type code |
| sw_trig_i | input | 1 | Software trigger pulse |
| ext_trig_i | input | 1 | External trigger level |
| conv_done_i | input | 1 | One-cycle conversion complete for the current entry |
| pause_i | input | 1 | Pause marker of the entry completing with conv_done_i |
| start_ptr_i | input | PTR_W | First command-word index of the queue |
| bound_ptr_i | input | PTR_W | Index just past the last entry |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | STAT_W | Status write data |
| status_o | output | STAT_W | Flags [2:0], queue state [6:4], pointer [8+:PTR_W] |
| conv_req_o | output | 1 | Conversion request for entry cwp_o |
| cwp_o | output | PTR_W | Current command-word pointer |

## Verification
The assertions assume that `conv_done_i` pulses only while a conversion is requested, that the boundary pointer lies above the start pointer, and that `ext_trig_i` is already synchronous to `clk_i`. The stimulus meets these assumptions. Done pulses are issued only after `conv_req_o` has been seen high. Random queues pick a start and a length of 1 to 8 so the bound never wraps. The external line is changed only at the falling clock edge. The timer modes are driven with a prescale of one, so each expected start cycle is an exact power of two after the mode change.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  localparam int MODE_W = 5;

  typedef enum logic [2:0] {
    QS_OFF    = 3'd0,
    QS_ARMED  = 3'd1,
    QS_ACTIVE = 3'd2,
    QS_PAUSED = 3'd3,
    QS_DONE   = 3'd4
  } qstate_e;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_TMR  = 2'd3
  } src_e;

  typedef struct packed {
    logic       valid;
    logic       cont;
    src_e       src;
    logic [4:0] exp;
  } mode_dec_t;
endpackage

// File: rtl/sqc_mode_dec.sv
module sqc_mode_dec
  import sqc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_dec_t         dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.src   = SRC_SW;
    if (mode_i >= 5'd11 && mode_i <= 5'd14) begin
      dec_o.valid = 1'b1;
      dec_o.src   = SRC_TMR;
      dec_o.exp   = mode_i + 5'd3;
    end else if (mode_i == 5'd17) begin
      dec_o.valid = 1'b1;
      dec_o.cont  = 1'b1;
    end else if (mode_i == 5'd18) begin
      dec_o.valid = 1'b1;
      dec_o.cont  = 1'b1;
      dec_o.src   = SRC_RISE;
    end else if (mode_i == 5'd19) begin
      dec_o.valid = 1'b1;
      dec_o.cont  = 1'b1;
      dec_o.src   = SRC_FALL;
    end else if (mode_i >= 5'd20 && mode_i <= 5'd30) begin
      dec_o.valid = 1'b1;
      dec_o.cont  = 1'b1;
      dec_o.src   = SRC_TMR;
      dec_o.exp   = mode_i - 5'd13;
    end
  end
endmodule

// File: rtl/sqc_edge.sv
module sqc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/sqc_timer.sv
module sqc_timer #(
  parameter int DIV     = 4,
  parameter int MAX_EXP = 17
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [4:0] exp_i,
  output logic       evt_o
);
  logic qtick;

  generate
    if (DIV == 1) begin : g_nodiv
      assign qtick = 1'b1;
    end else begin : g_div
      localparam int PCW = $clog2(DIV);
      localparam logic [PCW-1:0] PLAST = PCW'(DIV - 1);
      logic [PCW-1:0] pcnt;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             pcnt <= '0;
        else if (restart_i)      pcnt <= '0;
        else if (pcnt == PLAST)  pcnt <= '0;
        else                     pcnt <= pcnt + PCW'(1);
      end
      assign qtick = (pcnt == PLAST);
    end
  endgenerate

  logic [MAX_EXP-1:0] tcnt, mask;

  // shift out of range yields 0, minus one gives all ones for exp == MAX_EXP
  always_comb mask = ({{(MAX_EXP-1){1'b0}}, 1'b1} << exp_i) - {{(MAX_EXP-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tcnt <= '0;
    else if (restart_i) tcnt <= '0;
    else if (qtick)     tcnt <= tcnt + {{(MAX_EXP-1){1'b0}}, 1'b1};
  end

  assign evt_o = qtick && !restart_i && ((tcnt & mask) == mask);
endmodule

// File: rtl/scan_queue_ctrl.sv
module scan_queue_ctrl
  import sqc_pkg::*;
#(
  parameter int PTR_W        = 6,
  parameter int PRESCALE_DIV = 4,
  parameter int MAX_EXP      = 17,
  parameter int STAT_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic [4:0]        mode_i,
  input  logic              sw_trig_i,
  input  logic              ext_trig_i,
  input  logic              conv_done_i,
  input  logic              pause_i,
  input  logic [PTR_W-1:0]  start_ptr_i,
  input  logic [PTR_W-1:0]  bound_ptr_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic              conv_req_o,
  output logic [PTR_W-1:0]  cwp_o
);
  localparam int FLAG_W  = 3;
  localparam int QS_LSB  = 4;
  localparam int CWP_LSB = 8;

  mode_dec_t          dec;
  logic [4:0]         mode_q;
  logic               mode_chg;
  qstate_e            st_q, st_d;
  logic [PTR_W-1:0]   cwp_q, cwp_d;
  logic [FLAG_W-1:0]  flags_q, flag_set;
  logic               rise, fall, tmr_evt, trig, restart, at_end;
  logic               unused_wr;

  assign unused_wr = ^wr_data_i[STAT_W-1:FLAG_W];

  sqc_mode_dec u_dec (.mode_i(mode_i), .dec_o(dec));

  sqc_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(ext_trig_i),
    .rise_o(rise), .fall_o(fall)
  );

  assign mode_chg = (mode_i != mode_q);
  assign restart  = stop_i | mode_chg | (st_q == QS_OFF);

  sqc_timer #(.DIV(PRESCALE_DIV), .MAX_EXP(MAX_EXP)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
    .exp_i(dec.exp), .evt_o(tmr_evt)
  );

  always_comb begin
    unique case (dec.src)
      SRC_SW:   trig = sw_trig_i;
      SRC_RISE: trig = rise;
      SRC_FALL: trig = fall;
      default:  trig = tmr_evt;
    endcase
  end

  assign at_end = ((cwp_q + PTR_W'(1)) == bound_ptr_i);

  always_comb begin
    st_d     = st_q;
    cwp_d    = cwp_q;
    flag_set = '0;
    if (stop_i) begin
      st_d  = QS_OFF;
      cwp_d = start_ptr_i;
    end else if (mode_chg) begin
      st_d  = dec.valid ? QS_ARMED : QS_OFF;
      cwp_d = start_ptr_i;
    end else begin
      unique case (st_q)
        QS_OFF: begin
          cwp_d = start_ptr_i;
          if (dec.valid) st_d = QS_ARMED;
        end
        QS_ARMED: if (trig) begin
          st_d  = QS_ACTIVE;
          cwp_d = start_ptr_i;
        end
        QS_PAUSED: if (trig) st_d = QS_ACTIVE;
        QS_ACTIVE: begin
          if (trig) flag_set[2] = 1'b1;
          if (conv_done_i) begin
            if (at_end) begin
              flag_set[0] = 1'b1;
              cwp_d       = start_ptr_i;
              st_d        = dec.cont ? QS_ARMED : QS_DONE;
            end else begin
              cwp_d = cwp_q + PTR_W'(1);
              if (pause_i) begin
                flag_set[1] = 1'b1;
                st_d        = QS_PAUSED;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= QS_OFF;
      cwp_q   <= '0;
      mode_q  <= '0;
      flags_q <= '0;
    end else begin
      st_q   <= st_d;
      cwp_q  <= cwp_d;
      mode_q <= mode_i;
      if (stop_i)       flags_q <= '0;
      else if (wr_en_i) flags_q <= (flags_q & wr_data_i[FLAG_W-1:0]) | flag_set;
      else              flags_q <= flags_q | flag_set;
    end
  end

  always_comb begin
    status_o                         = '0;
    status_o[FLAG_W-1:0]             = flags_q;
    status_o[QS_LSB +: 3]            = st_q;
    status_o[CWP_LSB +: PTR_W]       = cwp_q;
  end

  assign conv_req_o = (st_q == QS_ACTIVE);
  assign cwp_o      = cwp_q;

  // unimplemented codes never let a conversion through
  p_disabled_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec.valid |=> !conv_req_o);

  p_start_from_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_req_o) |-> ($past(status_o[QS_LSB +: 3]) == QS_ARMED ||
                           $past(status_o[QS_LSB +: 3]) == QS_PAUSED));

  p_ptr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !conv_done_i && !stop_i && !mode_chg) |=> $stable(cwp_o));

  p_cf_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(conv_done_i && conv_req_o));

  p_tor_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> $past(conv_req_o));

  p_write_one_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[2:0] == 3'b111 && !stop_i) |=>
      ((status_o[2:0] & $past(status_o[2:0])) == $past(status_o[2:0])));

  p_stop_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (status_o[2:0] == 3'b000 && !conv_req_o));
endmodule

// File: tb/scan_queue_ctrl_tb.sv
module scan_queue_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 6;
  localparam int SW = 16;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          stop_i = 0, sw_trig_i = 0, ext_trig_i = 0, conv_done_i = 0, pause_i = 0;
  logic [4:0]    mode_i = '0;
  logic [PW-1:0] start_ptr_i = '0, bound_ptr_i = '0;
  logic          wr_en_i = 0;
  logic [SW-1:0] wr_data_i = '0;
  logic [SW-1:0] status_o;
  logic          conv_req_o;
  logic [PW-1:0] cwp_o;

  int n_chk = 0, n_fail = 0, cyc = 0, c0 = 0;
  bit finished = 0;

  scan_queue_ctrl #(.PTR_W(PW), .PRESCALE_DIV(1), .MAX_EXP(17), .STAT_W(SW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .mode_i(mode_i),
    .sw_trig_i(sw_trig_i), .ext_trig_i(ext_trig_i), .conv_done_i(conv_done_i),
    .pause_i(pause_i), .start_ptr_i(start_ptr_i), .bound_ptr_i(bound_ptr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .status_o(status_o),
    .conv_req_o(conv_req_o), .cwp_o(cwp_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  function automatic int tmr_exp(int code);
    return (code >= 20) ? code - 13 : code + 3;
  endfunction
  function automatic int nxt_ptr(int p);
    return (p + 1) % (1 << PW);
  endfunction
  function automatic int qs();
    return int'(status_o[6:4]);
  endfunction
  function automatic int flags();
    return int'(status_o[2:0]);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask
  task automatic set_mode(logic [4:0] m);
    mode_i = m; @(negedge clk_i);
  endtask
  task automatic sw_pulse();
    sw_trig_i = 1; @(negedge clk_i); sw_trig_i = 0;
  endtask
  task automatic done_pulse(bit p);
    conv_done_i = 1; pause_i = p; @(negedge clk_i); conv_done_i = 0; pause_i = 0;
  endtask
  task automatic wr(logic [SW-1:0] d);
    wr_en_i = 1; wr_data_i = d; @(negedge clk_i); wr_en_i = 0;
  endtask
  task automatic wait_req(int lim);
    while (!conv_req_o && (cyc - c0) < lim) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    int hits;
    void'($urandom(32'd1234));
    step(3); rst_ni = 1; step(1);

    // R1 reset and disabled modes
    chk("R1 reset status", int'(status_o), 0);
    chk("R1 reset req", int'(conv_req_o), 0);
    sw_pulse();
    chk("R1 code0 trig ignored qs", qs(), 0);
    chk("R1 code0 no flags", flags(), 0);
    start_ptr_i = 5; bound_ptr_i = 9;
    set_mode(5'b01111); sw_pulse();
    chk("R1 reserved req", int'(conv_req_o), 0);
    chk("R1 reserved qs", qs(), 0);
    chk("R1 reserved ptr", int'(cwp_o), 5);
    set_mode(5'b01010); ext_trig_i = 1; step(1); ext_trig_i = 0; sw_pulse();
    chk("R1 code01010 req", int'(conv_req_o), 0);
    chk("R1 code01010 flags", flags(), 0);

    // R2 / R3 software continuous
    start_ptr_i = 3; bound_ptr_i = 7;
    set_mode(5'b10001);
    chk("R2 armed", qs(), 1);
    sw_pulse();
    chk("R2 active", qs(), 2);
    chk("R2 req", int'(conv_req_o), 1);
    chk("R2 ptr start", int'(cwp_o), 3);
    for (int i = 0; i < 4; i++) begin
      done_pulse(0);
      if (i < 3) chk("R3 ptr step", int'(cwp_o), 4 + i);
    end
    chk("R3 cf set", int'(status_o[0]), 1);
    chk("R3 ptr back", int'(cwp_o), 3);
    chk("R3 rearmed", qs(), 1);

    // R8 overrun
    sw_pulse(); done_pulse(0);
    sw_pulse();
    chk("R8 tor set", int'(status_o[2]), 1);
    chk("R8 ptr unchanged", int'(cwp_o), 4);
    chk("R8 still active", qs(), 2);

    // R11 mode change mid-scan
    set_mode(5'b10010);
    chk("R11 rearm", qs(), 1);
    chk("R11 ptr start", int'(cwp_o), 3);
    chk("R11 req low", int'(conv_req_o), 0);

    // R9 writes
    wr(16'hFFFF);
    chk("R9 write ones keep", flags(), 5);
    wr(16'hFFFE);
    chk("R9 clear cf only", flags(), 4);
    wr(16'h0000);
    chk("R9 clear all", flags(), 0);
    chk("R9 qs ignores write", qs(), 1);
    chk("R9 ptr ignores write", int'(cwp_o), 3);

    // R4 external edges
    ext_trig_i = 1; step(1);
    chk("R4 rise starts", qs(), 2);
    repeat (4) done_pulse(0);
    ext_trig_i = 0; step(1);
    chk("R4 fall ignored in rise mode", qs(), 1);
    set_mode(5'b10011);
    ext_trig_i = 1; step(1);
    chk("R4 rise ignored in fall mode", qs(), 1);
    ext_trig_i = 0; step(1);
    chk("R4 fall starts", qs(), 2);
    repeat (4) done_pulse(0);
    wr(16'h0000);

    // R7 pause
    set_mode(5'b10001);
    sw_pulse(); done_pulse(1);
    chk("R7 pf set", int'(status_o[1]), 1);
    chk("R7 paused", qs(), 3);
    chk("R7 req low", int'(conv_req_o), 0);
    chk("R7 ptr advanced", int'(cwp_o), 4);
    step(2);
    chk("R7 stays paused", qs(), 3);
    sw_pulse();
    chk("R7 resume", qs(), 2);
    chk("R7 resume ptr", int'(cwp_o), 4);
    chk("R7 resume no tor", int'(status_o[2]), 0);
    done_pulse(0); done_pulse(0); done_pulse(1);
    chk("R7 pause ignored at end", qs(), 1);
    chk("R7 end cf", int'(status_o[0]), 1);

    // R9 set wins over clearing write
    sw_pulse(); repeat (3) done_pulse(0);
    wr_en_i = 1; wr_data_i = '0; conv_done_i = 1; step(1);
    wr_en_i = 0; conv_done_i = 0;
    chk("R9 set wins", flags(), 1);

    // R10 stop
    sw_pulse(); done_pulse(0);
    stop_i = 1; step(1); stop_i = 0;
    chk("R10 flags cleared", flags(), 0);
    chk("R10 qs off", qs(), 0);
    chk("R10 req low", int'(conv_req_o), 0);
    step(1);
    chk("R10 rearm after stop", qs(), 1);
    chk("R10 ptr start", int'(cwp_o), 3);

    // R5 continuous timer, code 10100
    start_ptr_i = 0; bound_ptr_i = 2;
    c0 = cyc; mode_i = 5'b10100;
    wait_req(1000);
    chk("R5 first start", cyc - c0, (1 << tmr_exp(20)) + 1);
    done_pulse(0); done_pulse(0);
    wait_req(2000);
    chk("R5 second start", cyc - c0, (2 << tmr_exp(20)) + 1);
    done_pulse(0); done_pulse(0);
    chk("R5 no overrun", int'(status_o[2]), 0);

    // R6 single interval timer, code 01011
    c0 = cyc; mode_i = 5'b01011;
    wait_req(40000);
    chk("R6 first start", cyc - c0, (1 << tmr_exp(11)) + 1);
    done_pulse(0); done_pulse(0);
    chk("R6 done state", qs(), 4);
    chk("R6 cf", int'(status_o[0]), 1);
    hits = 0;
    while ((cyc - c0) < (2 << tmr_exp(11)) + 10) begin
      @(negedge clk_i);
      if (conv_req_o) hits++;
    end
    chk("R6 no second scan", hits, 0);
    chk("R6 stays done", qs(), 4);

    // random queues, software continuous (R3, R7)
    set_mode(5'b10001);
    wr(16'h0000);
    for (int it = 0; it < 40; it++) begin
      int st, len, p, ex;
      st = int'($urandom % 32); len = 1 + int'($urandom % 8);
      start_ptr_i = PW'(st); bound_ptr_i = PW'(st + len);
      step(1);
      sw_pulse();
      chk("R2 rnd start ptr", int'(cwp_o), st);
      ex = st;
      for (int i = 0; i < len; i++) begin
        step(int'($urandom % 3));
        p = ($urandom % 4 == 0) ? 1 : 0;
        done_pulse(p[0]);
        if (i == len - 1) begin
          chk("R3 rnd end cf", int'(status_o[0]), 1);
          chk("R3 rnd end ptr", int'(cwp_o), st);
          chk("R3 rnd end armed", qs(), 1);
        end else begin
          ex = nxt_ptr(ex);
          chk("R3 rnd ptr", int'(cwp_o), ex);
          if (p != 0) begin
            chk("R7 rnd paused", qs(), 3);
            sw_pulse();
            chk("R7 rnd resumed", qs(), 2);
          end
        end
      end
      wr(16'h0000);
      chk("R9 rnd cleared", flags(), 0);
    end
    summary();
  end
endmodule